// File: doc/BRIEF.md
# I/O Fence Synchronization Controller

This block guards a processor's command port while a fence (I/O) transaction is in progress. A request whose I/O qualifier is high is acknowledged at once. From the next cycle on, every further request is refused until all outbound traffic has settled. The traffic has settled when each command FIFO and each write-data FIFO reports empty and the outstanding-read count of every memory target has dropped to zero.

The outstanding-read counts are kept inside the block, one counter per target. Each counter rises on a read-issue strobe and falls on a read-return strobe. When the fence is pending and everything has drained, the block raises a one-cycle completion pulse. That pulse has no timing tie to any read-data-valid signal. Ordinary requests are acknowledged in the cycle they arrive, as long as no fence is pending.

Top module: `fence_sync_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `ack_o` follows only a live request, `sync_done_o` is low, no fence is pending and every outstanding-read count is zero.
- R2: With no fence pending, a request with `io_i` low is acknowledged combinationally in the same cycle.
- R3: With no fence pending, a request with `io_i` high is acknowledged in the same cycle and starts a fence.
- R4: From the cycle after a fence is accepted until the cycle its completion pulse is visible, `ack_o` stays low whatever `req_i` and `io_i` do.
- R5: A pending fence cannot complete while any bit of `cmd_empty_i` is 0.
- R6: A pending fence cannot complete while any bit of `wdata_empty_i` is 0.
- R7: A pending fence cannot complete while any target's outstanding-read count is nonzero. The count rises by one on `rd_issue_i[t]` alone, falls by one on `rd_return_i[t]` alone, and is unchanged when both are high.
- R8: `sync_done_o` goes high for exactly one cycle, in the cycle after a pending fence first sees all drain conditions met. Requests are acknowledged again from that cycle on.
- R9: When `req_i` is low, `io_i` has no effect: there is no acknowledge, no fence and no completion pulse.
- R10: A return strobe on a target whose count is already zero leaves the count at zero. A count already at its maximum ignores an issue strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Command request strobe |
| io_i | input | 1 | I/O (fence) qualifier, meaningful only with `req_i` |
| ack_o | output | 1 | Request acknowledge (combinational) |
| cmd_empty_i | input | NUM_CMD_FIFOS | Empty flag of each outbound command FIFO |
| wdata_empty_i | input | NUM_WR_FIFOS | Empty flag of each write-data FIFO |
| rd_issue_i | input | NUM_TGT | Read command issued to target t |
| rd_return_i | input | NUM_TGT | Read data returned from target t |
| sync_done_o | output | 1 | One-cycle fence completion pulse |

## Verification
A stuck pending flag shows up at the ports at once. It either blocks `ack_o` forever after the first fence, or it lets `ack_o` through in the cycle right after a fence is accepted. A wrong outstanding-read count shows up only at the next fence. If the count is too high, the completion pulse never comes. If it is too low, the pulse comes before the last return. So the bench issues and retires reads and then fences, including the case of simultaneous issue and return and the case of a return at zero. A scoreboard fixes the exact cycle of every expected pulse, so a pulse that is early, late, doubled or missing is caught at that cycle.

// File: rtl/fence_sync_pkg.sv
package fence_sync_pkg;

    typedef struct packed {
        logic pending;   // fence accepted, waiting for drain
        logic done;      // completion pulse register
    } fence_state_t;

    localparam fence_state_t FENCE_IDLE = '{pending: 1'b0, done: 1'b0};

endpackage

// File: rtl/fence_rd_counter.sv
module fence_rd_counter #(
    parameter int CNT_W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic issue_i,
    input  logic ret_i,
    output logic zero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case ({issue_i, ret_i})
            2'b10: if (cnt_q != CNT_MAX)  cnt_d = cnt_q + 1'b1;
            2'b01: if (cnt_q != CNT_ZERO) cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;   // idle, or issue and return together
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= CNT_ZERO;
        else     cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == CNT_ZERO);
endmodule

// File: rtl/fence_drain_eval.sv
module fence_drain_eval #(
    parameter int NUM_CMD_FIFOS = 4,
    parameter int NUM_WR_FIFOS  = 2,
    parameter int NUM_TGT       = 2
) (
    input  logic [NUM_CMD_FIFOS-1:0] cmd_empty_i,
    input  logic [NUM_WR_FIFOS-1:0]  wdata_empty_i,
    input  logic [NUM_TGT-1:0]       tgt_zero_i,
    output logic                     queues_idle_o,
    output logic                     drained_o
);
    logic cmd_idle, wr_idle, tgt_idle;

    always_comb begin
        cmd_idle      = &cmd_empty_i;
        wr_idle       = &wdata_empty_i;
        tgt_idle      = &tgt_zero_i;
        queues_idle_o = cmd_idle && wr_idle;
        drained_o     = queues_idle_o && tgt_idle;
    end
endmodule

// File: rtl/fence_sync_ctrl.sv
module fence_sync_ctrl
    import fence_sync_pkg::*;
#(
    parameter int NUM_CMD_FIFOS = 4,
    parameter int NUM_WR_FIFOS  = 2,
    parameter int NUM_TGT       = 2,
    parameter int CNT_W         = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_i,
    input  logic                     io_i,
    output logic                     ack_o,
    input  logic [NUM_CMD_FIFOS-1:0] cmd_empty_i,
    input  logic [NUM_WR_FIFOS-1:0]  wdata_empty_i,
    input  logic [NUM_TGT-1:0]       rd_issue_i,
    input  logic [NUM_TGT-1:0]       rd_return_i,
    output logic                     sync_done_o
);
    fence_state_t st_d, st_q;

    logic [NUM_TGT-1:0] tgt_zero;
    logic               cnt_zero_all;
    logic               queues_idle;
    logic               drained;
    logic               fence_accept;

    // one outstanding-read tracker per memory target
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        fence_rd_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .issue_i (rd_issue_i[t]),
            .ret_i   (rd_return_i[t]),
            .zero_o  (tgt_zero[t])
        );
    end

    assign cnt_zero_all = &tgt_zero;

    fence_drain_eval #(
        .NUM_CMD_FIFOS (NUM_CMD_FIFOS),
        .NUM_WR_FIFOS  (NUM_WR_FIFOS),
        .NUM_TGT       (NUM_TGT)
    ) u_drain (
        .cmd_empty_i   (cmd_empty_i),
        .wdata_empty_i (wdata_empty_i),
        .tgt_zero_i    (tgt_zero),
        .queues_idle_o (queues_idle),
        .drained_o     (drained)
    );

    always_comb begin
        ack_o        = req_i && !st_q.pending;
        fence_accept = ack_o && io_i;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.pending && drained) begin
            st_d.pending = 1'b0;
            st_d.done    = 1'b1;
        end
        if (fence_accept) begin
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= FENCE_IDLE;
        else     st_q <= st_d;
    end

    assign sync_done_o = st_q.done;
endmodule

// File: rtl/fence_sync_chk.sv
module fence_sync_chk (
    input logic clk,
    input logic rst,
    input logic req_i,
    input logic io_i,
    input logic ack_o,
    input logic sync_done_o,
    input logic queues_idle_i,
    input logic cnt_zero_i
);
    // R2
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> req_i);

    // R4
    no_ack_after_fence_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i && io_i && ack_o) |=> !ack_o);

    // R8
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        sync_done_o |=> !sync_done_o);

    // R5
    done_after_queues_idle_chk: assert property (@(posedge clk) disable iff (rst)
        sync_done_o |-> $past(queues_idle_i));

    // R7
    done_after_counts_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sync_done_o |-> $past(cnt_zero_i));
endmodule

bind fence_sync_ctrl fence_sync_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_i         (req_i),
    .io_i          (io_i),
    .ack_o         (ack_o),
    .sync_done_o   (sync_done_o),
    .queues_idle_i (queues_idle),
    .cnt_zero_i    (cnt_zero_all)
);

// File: tb/fence_sync_ctrl_tb.sv
module fence_sync_ctrl_tb;
    localparam int NCF = 4;
    localparam int NWF = 2;
    localparam int NT  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, io = 1'b0;
    logic ack, done;
    logic [NCF-1:0] cmd_empty = '1;
    logic [NWF-1:0] wr_empty  = '1;
    logic [NT-1:0]  issue = '0, ret = '0;

    int cyc = 0;
    int n_chk = 0, n_bad = 0;
    int exp_q[$];
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    fence_sync_ctrl #(.NUM_CMD_FIFOS(NCF), .NUM_WR_FIFOS(NWF), .NUM_TGT(NT), .CNT_W(6)) u_dut (
        .clk(clk), .rst(rst), .req_i(req), .io_i(io), .ack_o(ack),
        .cmd_empty_i(cmd_empty), .wdata_empty_i(wr_empty),
        .rd_issue_i(issue), .rd_return_i(ret), .sync_done_o(done)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // monitor: compares completion pulses against the scoreboard
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (exp_q.size() > 0 && exp_q[0] < cyc) begin
                n_chk++; n_bad++;
                $display("FAIL R8: actual no pulse expected pulse at cycle %0d", exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (done) begin
                n_chk++;
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    void'(exp_q.pop_front());
                end else begin
                    n_bad++;
                    $display("FAIL R8: actual pulse at cycle %0d expected none", cyc);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic tick(); @(negedge clk); endtask

    // driver: apply request, check ack, queue expected pulse cycle
    task automatic drive_req(input logic r, input logic i, input logic exp_ack, input string tag);
        req = r; io = i;
        #1;
        check(tag, ack, exp_ack);
    endtask

    task automatic fence_and_queue(input int delay, input string tag);
        drive_req(1'b1, 1'b1, 1'b1, tag);
        if (delay > 0) exp_q.push_back(cyc + delay);
        tick();
        drive_req(1'b1, 1'b0, 1'b0, "R4 block");
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        check("R1 ack", ack, 1'b0);
        check("R1 done", done, 1'b0);

        // R2 ordinary request
        drive_req(1'b1, 1'b0, 1'b1, "R2");
        tick();
        // R9 qualifier without request
        for (int k = 0; k < 3; k++) begin
            drive_req(1'b0, 1'b1, 1'b0, "R9");
            tick();
        end
        drive_req(1'b1, 1'b0, 1'b1, "R9 no fence");
        tick();

        // R3 fence with everything drained: pulse two cycles later
        fence_and_queue(2, "R3");
        tick();
        drive_req(1'b1, 1'b0, 1'b1, "R8 ack resumes");
        tick();
        drive_req(1'b0, 1'b0, 1'b0, "R1 idle");
        tick();

        // R5 blocked by a command FIFO
        cmd_empty[2] = 1'b0;
        fence_and_queue(0, "R3 R5");
        for (int k = 0; k < 4; k++) begin
            tick();
            drive_req(1'b1, 1'b1, 1'b0, "R4 R5");
        end
        tick();
        cmd_empty[2] = 1'b1;
        exp_q.push_back(cyc + 1);
        drive_req(1'b0, 1'b0, 1'b0, "R5");
        tick(); tick();
        drive_req(1'b1, 1'b0, 1'b1, "R8 after R5");
        tick();

        // R6 blocked by a write-data FIFO
        wr_empty[1] = 1'b0;
        fence_and_queue(0, "R6");
        repeat (4) tick();
        cmd_empty[0] = 1'b0;
        wr_empty[1]  = 1'b1;
        tick();
        cmd_empty[0] = 1'b1;
        exp_q.push_back(cyc + 1);
        drive_req(1'b0, 1'b0, 1'b0, "R6");
        tick(); tick();

        // R7 counters: two reads on target 0, issue+return together on target 1
        issue = 2'b01; tick();
        issue = 2'b11; ret = 2'b10; tick();
        issue = 2'b00; ret = 2'b00;
        fence_and_queue(0, "R7");
        repeat (3) tick();
        ret = 2'b01; tick();
        ret = 2'b00;
        repeat (3) tick();
        ret = 2'b01;
        exp_q.push_back(cyc + 2);
        tick();
        ret = 2'b00;
        drive_req(1'b1, 1'b0, 1'b0, "R7 still blocked");
        tick(); tick();
        drive_req(1'b1, 1'b0, 1'b1, "R7 ack resumes");
        tick();

        // R10 return at zero is ignored
        ret = 2'b10; tick();
        ret = 2'b00; issue = 2'b10; tick();
        issue = 2'b00;
        fence_and_queue(0, "R10");
        repeat (4) tick();
        ret = 2'b10;
        exp_q.push_back(cyc + 2);
        tick();
        ret = 2'b00;
        drive_req(1'b0, 1'b0, 1'b0, "R10");
        repeat (4) tick();

        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R8: actual %0d pending pulses expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule